// File: doc/BRIEF.md
# Mesh Vertex Sequencer

This block drives a microcoded execution core across a two-dimensional grid of vertices. A host pulse on the start input latches a base address and the last column and row indices, then the sequencer visits each grid point row by row. At every point it loads the point's coordinates into the core's two coordinate registers and restarts the core's program counter at zero. It then lets the core run until the core reports a vector-output instruction.

On a vector output the sequencer takes the core's two operands and turns them into two 32-bit memory writes at an address derived from the grid position with a fixed row stride of 128 cells. The words are sent big-endian on a valid/ready write port. A guard counter cuts off a vertex whose program never reaches a vector output. When the last point is done the sequencer records the vertex count, raises a one-cycle interrupt and drops busy.

A small helper maps a code-page number and a window offset onto the flat index of the microcode store.

Top module: `mesh_walker`

## Requirements
- R1: A `startReq` pulse while idle latches `cfgBase`, `cfgHLast` and `cfgVLast` and makes `busy` high from the next cycle. A `startReq` while busy is ignored: it does not restart the walk, and the walk keeps the configuration it latched.
- R2: Points are visited with X running from 0 to `cfgHLast` inclusive inside Y running from 0 to `cfgVLast` inclusive, so X varies fastest.
- R3: For each point `gprLoad` and `pcClear` pulse together for one cycle with `gprX`/`gprY` giving the point's coordinates. `coreRun` is high from the next cycle until the point ends.
- R4: A vector output at point (X,Y) produces two writes: operand A at `base + 8*(128*Y + X)` and then operand B at that address plus 4.
- R5: Each write carries its operand byte-reversed. Operand bits [7:0] appear on `memData[31:24]` and operand bits [31:24] appear on `memData[7:0]`.
- R6: `memValid` stays high with `memAddr` and `memData` stable until `memReady` is seen. The operand-B write is presented only after the operand-A write has been accepted.
- R7: After the operand-B write is accepted, `lastDma` holds the address of that write.
- R8: When 2048 `insnStep` pulses arrive at one point without `vecOut`, that point ends with no write and the walk moves on. If `vecOut` arrives in the same cycle as the 2048th step, the write pair is still issued.
- R9: After the last point, `irq` is high for exactly one cycle while `busy` is still high, and `busy` is low in the cycle after. During that `irq` cycle `vertexCount` equals `(cfgHLast+1)*(cfgVLast+1)`.
- R10: `codeIndex` equals `codePage*512 + winOffset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse (bit 0 of the control write) |
| cfgBase | input | 32 | Mesh output base address |
| cfgHLast | input | 7 | Last column index |
| cfgVLast | input | 7 | Last row index |
| busy | output | 1 | Walk in progress |
| irq | output | 1 | One-cycle completion pulse |
| vertexCount | output | 15 | Vertices processed by the last walk |
| gprLoad | output | 1 | Write coordinates into core registers 0 and 1 |
| pcClear | output | 1 | Reset core program counter to 0 |
| gprX | output | 7 | Current X coordinate |
| gprY | output | 7 | Current Y coordinate |
| coreRun | output | 1 | Core may execute |
| vecOut | input | 1 | Core reached a vector-output instruction |
| insnStep | input | 1 | Core executed one instruction |
| vecA | input | 32 | Vector operand A |
| vecB | input | 32 | Vector operand B |
| memValid | output | 1 | Write request valid |
| memReady | input | 1 | Write request accepted |
| memAddr | output | 32 | Write address |
| memData | output | 32 | Write data, big-endian |
| lastDma | output | 32 | Address of the last accepted second word |
| codePage | input | 2 | Microcode page selector |
| winOffset | input | 9 | Offset within the microcode window |
| codeIndex | output | 11 | Flat microcode store index |

## Verification
The guard counter and the vector-output decode can fire in the same cycle: the core's 2048th instruction at one point may also be its vector output. The bench provokes this by driving `insnStep` on every running cycle at a chosen point and raising `vecOut` together with the 2048th step. The result passes only if the write pair for that point still appears. At a second point the same stepping runs without `vecOut`, and the bench confirms that exactly 2048 steps were taken and that no write was issued for that point.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RUN, ST_WRA, ST_WRB, ST_NEXT, ST_DONE
  } walkState_e;

  typedef struct packed {
    logic clearPos;
    logic stepPos;
    logic capture;
    logic selB;
    logic commitLast;
    logic finish;
  } walkCtl_t;
endpackage

// File: rtl/mesh_ctrl.sv
module mesh_ctrl
  import mesh_pkg::*;
#(
  parameter int GUARD_LIMIT = 2048
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startReq,
  input  logic     vecOut,
  input  logic     insnStep,
  input  logic     memReady,
  input  logic     atMeshEnd,
  output walkCtl_t ctl,
  output logic     busy,
  output logic     irq,
  output logic     gprLoad,
  output logic     pcClear,
  output logic     coreRun,
  output logic     memValid
);
  localparam int GW = $clog2(GUARD_LIMIT);

  walkState_e state, nextState;
  logic [GW-1:0] guardCnt;
  logic guardHit;

  assign guardHit = insnStep && !vecOut && (guardCnt == GW'(GUARD_LIMIT - 1));

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        nextState = ST_LOAD;
        ctl.clearPos = 1'b1;
      end
      ST_LOAD: nextState = ST_RUN;
      ST_RUN: begin
        if (vecOut) begin
          nextState = ST_WRA;
          ctl.capture = 1'b1;
        end else if (guardHit) begin
          nextState = ST_NEXT;
        end
      end
      ST_WRA: if (memReady) nextState = ST_WRB;
      ST_WRB: begin
        ctl.selB = 1'b1;
        if (memReady) begin
          nextState = ST_NEXT;
          ctl.commitLast = 1'b1;
        end
      end
      ST_NEXT: begin
        if (atMeshEnd) begin
          nextState = ST_DONE;
          ctl.finish = 1'b1;
        end else begin
          nextState = ST_LOAD;
          ctl.stepPos = 1'b1;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      guardCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_LOAD) guardCnt <= '0;
      else if (state == ST_RUN && insnStep && !vecOut) guardCnt <= guardCnt + 1'b1;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign irq      = (state == ST_DONE);
  assign gprLoad  = (state == ST_LOAD);
  assign pcClear  = (state == ST_LOAD);
  assign coreRun  = (state == ST_RUN);
  assign memValid = (state == ST_WRA) || (state == ST_WRB);

  // R1
  startBusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startReq && !busy) |=> busy);
  // R3
  loadThenRun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gprLoad |=> (coreRun && !gprLoad));
  // R6
  validHold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> memValid);
  // R9
  irqPulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (!irq && !busy));
  // R8
  guardAbort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coreRun && guardHit) |=> (!coreRun && !memValid));
endmodule

// File: rtl/mesh_dpath.sv
module mesh_dpath
  import mesh_pkg::*;
#(
  parameter int COORD_W    = 7,
  parameter int STRIDE_LOG = 7,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  walkCtl_t               ctl,
  input  logic [ADDR_W-1:0]      cfgBase,
  input  logic [COORD_W-1:0]     cfgHLast,
  input  logic [COORD_W-1:0]     cfgVLast,
  input  logic [DATA_W-1:0]      vecA,
  input  logic [DATA_W-1:0]      vecB,
  output logic [COORD_W-1:0]     posX,
  output logic [COORD_W-1:0]     posY,
  output logic                   atMeshEnd,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memData,
  output logic [ADDR_W-1:0]      lastDma,
  output logic [2*COORD_W:0]     vertexCount
);
  localparam int CNT_W  = 2 * COORD_W + 1;
  localparam int NBYTES = DATA_W / 8;
  localparam int WORD_SHIFT = $clog2(2 * NBYTES);

  logic [ADDR_W-1:0]  baseReg, pairAddr, cellIdx;
  logic [COORD_W-1:0] hLastReg, vLastReg;
  logic [DATA_W-1:0]  opAReg, opBReg, wordSel;
  logic [CNT_W-1:0]   colCnt, rowCnt;
  logic               atRowEnd;

  assign atRowEnd  = (posX == hLastReg);
  assign atMeshEnd = atRowEnd && (posY == vLastReg);
  assign cellIdx   = (ADDR_W'(posY) << STRIDE_LOG) + ADDR_W'(posX);
  assign colCnt    = CNT_W'(hLastReg) + CNT_W'(1);
  assign rowCnt    = CNT_W'(vLastReg) + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posX <= '0;
      posY <= '0;
      baseReg <= '0;
      hLastReg <= '0;
      vLastReg <= '0;
      pairAddr <= '0;
      opAReg <= '0;
      opBReg <= '0;
      lastDma <= '0;
      vertexCount <= '0;
    end else begin
      if (ctl.clearPos) begin
        posX <= '0;
        posY <= '0;
        baseReg <= cfgBase;
        hLastReg <= cfgHLast;
        vLastReg <= cfgVLast;
      end else if (ctl.stepPos) begin
        if (atRowEnd) begin
          posX <= '0;
          posY <= posY + 1'b1;
        end else begin
          posX <= posX + 1'b1;
        end
      end
      if (ctl.capture) begin
        pairAddr <= baseReg + (cellIdx << WORD_SHIFT);
        opAReg <= vecA;
        opBReg <= vecB;
      end
      if (ctl.commitLast) lastDma <= memAddr;
      if (ctl.finish) vertexCount <= colCnt * rowCnt;
    end
  end

  assign memAddr = ctl.selB ? pairAddr + ADDR_W'(NBYTES) : pairAddr;
  assign wordSel = ctl.selB ? opBReg : opAReg;

  for (genvar i = 0; i < NBYTES; i++) begin : g_swap
    assign memData[8*i +: 8] = wordSel[8*(NBYTES-1-i) +: 8];
  end

  // R2
  stepX_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.stepPos && !ctl.clearPos && !atRowEnd) |=> (posX == $past(posX) + 1'b1 && posY == $past(posY)));
  // R2
  stepY_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.stepPos && !ctl.clearPos && atRowEnd) |=> (posX == '0 && posY == $past(posY) + 1'b1));
endmodule

// File: rtl/mesh_walker.sv
module mesh_walker
  import mesh_pkg::*;
#(
  parameter int COORD_W     = 7,
  parameter int STRIDE_LOG  = 7,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int GUARD_LIMIT = 2048,
  parameter int PAGE_W      = 2,
  parameter int WIN_W       = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    startReq,
  input  logic [ADDR_W-1:0]       cfgBase,
  input  logic [COORD_W-1:0]      cfgHLast,
  input  logic [COORD_W-1:0]      cfgVLast,
  output logic                    busy,
  output logic                    irq,
  output logic [2*COORD_W:0]      vertexCount,
  output logic                    gprLoad,
  output logic                    pcClear,
  output logic [COORD_W-1:0]      gprX,
  output logic [COORD_W-1:0]      gprY,
  output logic                    coreRun,
  input  logic                    vecOut,
  input  logic                    insnStep,
  input  logic [DATA_W-1:0]       vecA,
  input  logic [DATA_W-1:0]       vecB,
  output logic                    memValid,
  input  logic                    memReady,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memData,
  output logic [ADDR_W-1:0]       lastDma,
  input  logic [PAGE_W-1:0]       codePage,
  input  logic [WIN_W-1:0]        winOffset,
  output logic [PAGE_W+WIN_W-1:0] codeIndex
);
  walkCtl_t ctl;
  logic atMeshEnd;

  mesh_ctrl #(.GUARD_LIMIT(GUARD_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .vecOut(vecOut),
    .insnStep(insnStep), .memReady(memReady), .atMeshEnd(atMeshEnd),
    .ctl(ctl), .busy(busy), .irq(irq), .gprLoad(gprLoad), .pcClear(pcClear),
    .coreRun(coreRun), .memValid(memValid)
  );

  mesh_dpath #(.COORD_W(COORD_W), .STRIDE_LOG(STRIDE_LOG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .cfgBase(cfgBase), .cfgHLast(cfgHLast),
    .cfgVLast(cfgVLast), .vecA(vecA), .vecB(vecB), .posX(gprX), .posY(gprY),
    .atMeshEnd(atMeshEnd), .memAddr(memAddr), .memData(memData),
    .lastDma(lastDma), .vertexCount(vertexCount)
  );

  assign codeIndex = {codePage, winOffset};

  // R6
  addrHold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memValid && !memReady) |=> ($stable(memAddr) && $stable(memData)));
endmodule

// File: tb/mesh_walker_tb.sv
module mesh_walker_tb;
  localparam int LIMIT = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0;
  logic [31:0] cfgBase = '0;
  logic [6:0] cfgHLast = '0, cfgVLast = '0;
  logic busy, irq, gprLoad, pcClear, coreRun, memValid;
  logic [14:0] vertexCount;
  logic [6:0] gprX, gprY;
  logic vecOut = 1'b0, insnStep = 1'b0, memReady = 1'b0;
  logic [31:0] vecA = '0, vecB = '0;
  logic [31:0] memAddr, memData, lastDma;
  logic [1:0] codePage = '0;
  logic [8:0] winOffset = '0;
  logic [10:0] codeIndex;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mesh_walker u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cfgBase(cfgBase),
    .cfgHLast(cfgHLast), .cfgVLast(cfgVLast), .busy(busy), .irq(irq),
    .vertexCount(vertexCount), .gprLoad(gprLoad), .pcClear(pcClear),
    .gprX(gprX), .gprY(gprY), .coreRun(coreRun), .vecOut(vecOut),
    .insnStep(insnStep), .vecA(vecA), .vecB(vecB), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .lastDma(lastDma), .codePage(codePage), .winOffset(winOffset),
    .codeIndex(codeIndex)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Reference model of one walk, stepped on every negative edge.
  task automatic runWalk(input int hl, input int vl, input logic [31:0] base,
                         input bit stall, input int abortIdx, input int collideIdx,
                         input int restartAt);
    logic [31:0] qAddr[$];
    logic [31:0] qData[$];
    bit          qIsB[$];
    int ex = 0, ey = 0, vidx = -1, waitCnt = 0, steps = 0, irqs = 0, cyc = 0;
    int total = (hl + 1) * (vl + 1);
    bit done = 0, lastPending = 0, holdPending = 0;
    logic [31:0] expLast = '0, holdAddr = '0, holdData = '0;
    int cx = 0, cy = 0;
    cfgBase = base; cfgHLast = 7'(hl); cfgVLast = 7'(vl);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    chk(busy === 1'b1, "R1", "busy after start", 32'(busy), 32'd1);
    while (!done) begin
      if (lastPending) begin
        chk(lastDma === expLast, "R7", "lastDma", lastDma, expLast);
        lastPending = 0;
      end
      if (gprLoad) begin
        if (vidx == abortIdx && vidx >= 0)
          chk(steps == LIMIT, "R8", "steps before abort", 32'(steps), 32'(LIMIT));
        vidx++;
        chk(gprX === 7'(ex) && gprY === 7'(ey), "R2", "visit order xy",
            {9'd0, gprX, 9'd0, gprY}, {9'd0, 7'(ex), 9'd0, 7'(ey)});
        chk(pcClear === 1'b1, "R3", "pc clear with load", 32'(pcClear), 32'd1);
        cx = ex; cy = ey;
        if (ex == hl) begin ex = 0; ey++; end else ex++;
        steps = 0;
        waitCnt = 2;
      end
      if (memValid && holdPending)
        chk(memAddr === holdAddr && memData === holdData, "R6", "held request", memAddr, holdAddr);
      if (irq) begin
        irqs++;
        chk(vertexCount === 15'(total), "R9", "vertex count", 32'(vertexCount), 32'(total));
        chk(vidx == total - 1, "R2", "all points visited", 32'(vidx), 32'(total - 1));
        done = 1;
      end
      // drive next cycle
      startReq = (cyc == restartAt) ? 1'b1 : 1'b0;
      if (cyc == restartAt) cfgHLast = 7'(hl + 3);
      memReady = stall ? ((cyc % 3) == 2) : 1'b1;
      if (memValid) begin
        if (qAddr.size() == 0) begin
          chk(1'b0, "R8", "unexpected write", memAddr, 32'd0);
        end else if (memReady) begin
          chk(memAddr === qAddr[0], qIsB[0] ? "R6" : "R4", "write address", memAddr, qAddr[0]);
          chk(memData === qData[0], "R5", "write data", memData, qData[0]);
          if (qIsB[0]) begin lastPending = 1; expLast = qAddr[0]; end
          void'(qAddr.pop_front()); void'(qData.pop_front()); void'(qIsB.pop_front());
        end
        holdPending = !memReady;
        holdAddr = memAddr; holdData = memData;
      end else holdPending = 0;
      vecOut = 1'b0; insnStep = 1'b0;
      if (coreRun) begin
        bit fire = 0;
        if (vidx == abortIdx) begin
          insnStep = 1'b1; steps++;
        end else if (vidx == collideIdx) begin
          insnStep = 1'b1; steps++;
          fire = (steps == LIMIT);
        end else if (waitCnt == 0) fire = 1;
        else begin waitCnt--; insnStep = 1'b1; end
        if (fire) begin
          logic [31:0] a, b, ad;
          a = {8'h3C, 8'(vidx), 8'h5A, 8'(cx)};
          b = {8'(cy), 8'hE1, 8'(vidx), 8'h07};
          vecOut = 1'b1; vecA = a; vecB = b;
          ad = base + 32'(8 * (128 * cy + cx));
          qAddr.push_back(ad);     qData.push_back(bswap(a)); qIsB.push_back(1'b0);
          qAddr.push_back(ad + 4); qData.push_back(bswap(b)); qIsB.push_back(1'b1);
        end
      end
      cyc++;
      @(negedge clk);
    end
    vecOut = 1'b0; insnStep = 1'b0; startReq = 1'b0;
    chk(busy === 1'b0 && irq === 1'b0, "R9", "idle after irq", {busy, irq}, 32'd0);
    chk(qAddr.size() == 0, "R8", "pending writes at end", 32'(qAddr.size()), 32'd0);
    repeat (3) begin
      @(negedge clk);
      if (irq) irqs++;
    end
    chk(irqs == 1, "R1", "single completion", 32'(irqs), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R9", "reset busy", 32'(busy), 32'd0);
    chk(irq === 1'b0, "R9", "reset irq", 32'(irq), 32'd0);
    chk(memValid === 1'b0, "R6", "reset memValid", 32'(memValid), 32'd0);

    // R10 code window mapping
    codePage = 2'd0; winOffset = 9'd5; #1;
    chk(codeIndex === 11'd5, "R10", "page0", 32'(codeIndex), 32'd5);
    codePage = 2'd1; winOffset = 9'd0; #1;
    chk(codeIndex === 11'd512, "R10", "page1", 32'(codeIndex), 32'd512);
    codePage = 2'd3; winOffset = 9'd511; #1;
    chk(codeIndex === 11'd2047, "R10", "page3 top", 32'(codeIndex), 32'd2047);

    @(negedge clk);
    runWalk(2, 1, 32'h0000_1000, 1'b0, -1, -1, -1);     // R2 R3 R4 R5 R7 R9
    runWalk(0, 0, 32'h8000_0010, 1'b1, -1, -1, -1);     // R6 single point, stalls
    runWalk(1, 1, 32'h2000_0000, 1'b0, 1, 2, 5);        // R8 abort and collision, R1 restart ignored
    runWalk(127, 1, 32'h0100_0000, 1'b1, -1, -1, 40);   // R4 full row stride, R6

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule